// File: doc/BRIEF.md
# DMA Channel Interrupt Status Aggregator

This block gathers completion events and fault events from a group of DMA channels and turns them into sticky status bits that software can read and acknowledge. Each channel reports a one-cycle completion pulse, together with a flag saying whether the finished transfer asked for a completion interrupt, and a one-cycle fault pulse. Two per-channel enable vectors pick which latched events may reach the masked views. A single interrupt line rises while any enabled event is pending.

Software reads a small set of word registers through a plain read/write port. For each event class there is a raw view, a masked view and a write-one-to-clear register. A combined word ORs both masked views per channel. A handler can read both masked words, service every set bit and acknowledge several channels with one write.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset every raw latch is zero, `irq` is low, and reads of all mapped offsets return zero.
- R2: A `done_pulse[n]` with `done_irq_req[n]` high sets bit n of the raw completion word (offset 0x14) at the next clock edge. A pulse with `done_irq_req[n]` low sets nothing.
- R3: A `fault_pulse[n]` sets bit n of the raw fault word (offset 0x18) at the next clock edge.
- R4: The masked completion word (offset 0x04) is the raw completion word ANDed with `done_en`. The masked fault word (offset 0x0C) is the raw fault word ANDed with `fault_en`.
- R5: Writing the completion acknowledge offset 0x08 clears each raw completion bit whose write-data bit is 1. Bits written as 0 keep their value.
- R6: Writing the fault acknowledge offset 0x10 clears each raw fault bit whose write-data bit is 1. Bits written as 0 keep their value.
- R7: If an event and an acknowledge for the same bit arrive in the same cycle, the bit is set after that edge.
- R8: Bit n of the combined word (offset 0x00) is the OR of masked completion bit n and masked fault bit n.
- R9: `irq` is high exactly when the combined word is nonzero. It changes in the same cycle as the enables or the raw latches.
- R10: Raw latching does not depend on the enables. An event caught while its enable is low shows up in the masked view as soon as the enable is raised.
- R11: Reads of any unmapped offset return zero. Writes to offsets other than 0x08 and 0x10 change no state.
- R12: Bit n of every status and acknowledge word belongs to channel n. Bits at and above `NCH` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_pulse | input | NCH | Per-channel one-cycle transfer-complete pulse |
| done_irq_req | input | NCH | Per-channel flag: the finished transfer requested a completion interrupt |
| fault_pulse | input | NCH | Per-channel one-cycle fault pulse |
| done_en | input | NCH | Per-channel completion enable |
| fault_en | input | NCH | Per-channel fault enable |
| reg_addr | input | AW | Byte offset for read and write |
| reg_we | input | 1 | Write strobe, acts at the clock edge |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
Event pulses and acknowledge writes act at the rising edge that samples them. The latched result is therefore due one cycle after the stimulus. Read data and `irq` follow the latches and enables combinationally, with no added delay. The bench drives every input on the falling edge, lets exactly one rising edge pass, and samples the read port and `irq` on the next falling edge. Enable changes are sampled after a short settle delay, with no clock edge in between.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  // byte offsets decoded by software
  localparam int unsigned OFS_COMBINED  = 32'h00;
  localparam int unsigned OFS_DONE_MSK  = 32'h04;
  localparam int unsigned OFS_DONE_ACK  = 32'h08;
  localparam int unsigned OFS_FAULT_MSK = 32'h0C;
  localparam int unsigned OFS_FAULT_ACK = 32'h10;
  localparam int unsigned OFS_DONE_RAW  = 32'h14;
  localparam int unsigned OFS_FAULT_RAW = 32'h18;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] raw_o
);
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         raw_o[g] <= 1'b0;
        else if (set_i[g])  raw_o[g] <= 1'b1;   // event beats acknowledge
        else if (clr_i[g])  raw_o[g] <= 1'b0;
      end
    end
  endgenerate

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((raw_o & $past(set_i)) == $past(set_i)));
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((raw_o & $past(clr_i & ~set_i)) == '0));
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_o & ~$past(raw_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/irq_reg_mux.sv
module irq_reg_mux
  import dma_irq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic [AW-1:0]  addr,
  input  logic [NCH-1:0] done_raw,
  input  logic [NCH-1:0] fault_raw,
  input  logic [NCH-1:0] done_msk,
  input  logic [NCH-1:0] fault_msk,
  output logic [DW-1:0]  rdata
);
  logic [NCH-1:0] sel;
  always_comb begin
    sel = '0;
    if      (addr == AW'(OFS_COMBINED))  sel = done_msk | fault_msk;
    else if (addr == AW'(OFS_DONE_MSK))  sel = done_msk;
    else if (addr == AW'(OFS_FAULT_MSK)) sel = fault_msk;
    else if (addr == AW'(OFS_DONE_RAW))  sel = done_raw;
    else if (addr == AW'(OFS_FAULT_RAW)) sel = fault_raw;
    rdata = DW'(sel);
  end

  always_comb begin
    if (addr != AW'(OFS_COMBINED) && addr != AW'(OFS_DONE_MSK) &&
        addr != AW'(OFS_FAULT_MSK) && addr != AW'(OFS_DONE_RAW) &&
        addr != AW'(OFS_FAULT_RAW))
      assert_unmapped_zero_R11: assert (rdata == '0);
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] done_pulse,
  input  logic [NCH-1:0] done_irq_req,
  input  logic [NCH-1:0] fault_pulse,
  input  logic [NCH-1:0] done_en,
  input  logic [NCH-1:0] fault_en,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_we,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq
);
  logic [NCH-1:0] done_raw, fault_raw, done_msk, fault_msk;
  logic [NCH-1:0] done_set, done_clr, fault_clr;

  assign done_set  = done_pulse & done_irq_req;
  assign done_clr  = (reg_we && reg_addr == AW'(OFS_DONE_ACK))  ? reg_wdata[NCH-1:0] : '0;
  assign fault_clr = (reg_we && reg_addr == AW'(OFS_FAULT_ACK)) ? reg_wdata[NCH-1:0] : '0;

  irq_sticky_bank #(.NCH(NCH)) u_done (
    .clk(clk), .rst_n(rst_n), .set_i(done_set), .clr_i(done_clr), .raw_o(done_raw));
  irq_sticky_bank #(.NCH(NCH)) u_fault (
    .clk(clk), .rst_n(rst_n), .set_i(fault_pulse), .clr_i(fault_clr), .raw_o(fault_raw));

  assign done_msk  = done_raw & done_en;
  assign fault_msk = fault_raw & fault_en;
  assign irq       = |(done_msk | fault_msk);

  irq_reg_mux #(.NCH(NCH), .AW(AW), .DW(DW)) u_mux (
    .addr(reg_addr), .done_raw(done_raw), .fault_raw(fault_raw),
    .done_msk(done_msk), .fault_msk(fault_msk), .rdata(reg_rdata));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(done_raw & done_en) || |(fault_raw & fault_en)));
  assert_req_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done_pulse & ~done_irq_req & ~done_raw)) |=>
      ((done_raw & $past(done_pulse & ~done_irq_req & ~done_raw)) == '0));
endmodule

// File: tb/sim_dma_irq_agg.sv
`timescale 1ns/1ps
module sim_dma_irq_agg;
  localparam int NCH = 8, AW = 8, DW = 32;
  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] done_pulse = '0, done_irq_req = '0, fault_pulse = '0;
  logic [NCH-1:0] done_en = '0, fault_en = '0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_we = 0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dma_irq_agg #(.NCH(NCH), .AW(AW), .DW(DW)) u0 (.*);

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    reg_addr = a; #0.5;
    chk(req, reg_rdata, exp);
  endtask

  // one edge: drive at falling edge, hold over rising edge, clear at next falling edge
  task automatic step(input logic [NCH-1:0] dp, input logic [NCH-1:0] dr,
                      input logic [NCH-1:0] fp, input logic we,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    done_pulse = dp; done_irq_req = dr; fault_pulse = fp;
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    done_pulse = '0; done_irq_req = '0; fault_pulse = '0; reg_we = 0; reg_wdata = '0;
  endtask

  task automatic t_reset;
    rd("R1", 8'h00, 0); rd("R1", 8'h04, 0); rd("R1", 8'h0C, 0);
    rd("R1", 8'h14, 0); rd("R1", 8'h18, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_done;
    done_en = '1;
    step(8'h08, 8'h08, 0, 0, 0, 0);
    rd("R2", 8'h14, 32'h08);
    rd("R4", 8'h04, 32'h08);
    rd("R8", 8'h00, 32'h08);
    chk("R9 irq", irq, 1);
    step(8'h20, 8'h00, 0, 0, 0, 0);
    rd("R2 no req", 8'h14, 32'h08);
    step(0, 0, 0, 1, 8'h08, 32'h00);
    rd("R5 zero keeps", 8'h14, 32'h08);
    step(0, 0, 0, 1, 8'h08, 32'hFFFF_FF08);
    rd("R5 clear", 8'h14, 32'h00);
    chk("R9 irq low", irq, 0);
  endtask

  task automatic t_fault;
    fault_en = '0;
    step(0, 0, 8'h42, 0, 0, 0);
    rd("R3", 8'h18, 32'h42);
    rd("R10 masked off", 8'h0C, 32'h00);
    chk("R10 irq", irq, 0);
    fault_en = 8'h02; #0.5;
    rd("R10 enable late", 8'h0C, 32'h02);
    rd("R8", 8'h00, 32'h02);
    chk("R9 irq", irq, 1);
    step(0, 0, 0, 1, 8'h10, 32'h02);
    rd("R6", 8'h18, 32'h40);
    chk("R9 irq off", irq, 0);
    step(0, 0, 0, 1, 8'h10, 32'h40);
    rd("R6 all", 8'h18, 32'h00);
  endtask

  task automatic t_race;
    step(8'h80, 8'h80, 0, 0, 0, 0);
    step(8'h01, 8'h01, 0, 1, 8'h08, 32'h81);
    rd("R7", 8'h14, 32'h01);
    step(0, 0, 8'h04, 1, 8'h10, 32'h04);
    rd("R7 fault", 8'h18, 32'h04);
  endtask

  task automatic t_combined;
    fault_en = '1;
    step(8'h04, 8'h04, 8'h10, 0, 0, 0);
    rd("R8 combined", 8'h00, 32'h15);
    rd("R12 channel map", 8'h04, 32'h05);
  endtask

  task automatic t_unmapped;
    rd("R11", 8'h1C, 0);
    rd("R11", 8'h40, 0);
    rd("R11 ack reads", 8'h08, 0);
    step(0, 0, 0, 1, 8'h14, 32'hFF);
    step(0, 0, 0, 1, 8'h00, 32'hFF);
    rd("R11 write ignored", 8'h14, 32'h05);
    rd("R11 write ignored", 8'h18, 32'h14);
    done_en = '0; fault_en = '0; #0.5;
    chk("R9 masked all", irq, 0);
    rd("R4 masked", 8'h04, 0);
  endtask

  initial begin
    fork
      begin
        #1 rst_n = 0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1;
        t_reset;
        t_done;
        t_fault;
        t_race;
        t_combined;
        t_unmapped;
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog got timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule